// File: doc/BRIEF.md
# Multi-Mode Receive Data Link Deformatter

This block sits behind a line framer and turns a serial data link bit stream into bytes for a receive FIFO. The framer presents one bit per cycle in which `bitValid` is high and marks the first bit of each multiframe with `mfSync`. A two-bit run-time mode picks what the block does with those bits. Two modes are bit-oriented HDLC deframing: one checks and strips a 16-bit frame check sequence, and the other passes every recovered byte through unchecked. The other two modes are transparent and pack either 8 or 6 received bits into each FIFO entry, aligned to the multiframe.

In the HDLC modes the block finds 0x7E flags, drops the zero inserted after five ones, spots runs of seven ones as aborts, and gives one status pulse per frame: good, bad (FCS mismatch, too short or not a whole number of bytes), or aborted. In FCS mode the last two bytes of each frame are held back, so the check bytes never reach the FIFO. An interrupt-event pulse goes with every frame status in the HDLC modes and with every byte written in the transparent modes. Pulling `rxEn` low stops all output and clears the internal state. The mode should only be changed while the block is disabled.

Top module: `hdlc_rx_deformatter`

## Requirements
- R1: `mode` selects 00 = HDLC with FCS check, 01 = HDLC without FCS, 10 = transparent 8 bits per byte, 11 = transparent 6 bits per byte. In every mode the first bit received is bit 0 of the byte written.
- R2: In the HDLC modes, a 0 that follows five consecutive 1s is deleted before bytes are assembled, so payload bytes such as 0xFF, 0xF8 and 0x7E come out unchanged.
- R3: In the HDLC modes, flag bits are never written. A run of back-to-back flags, or of flags that share a zero, produces no write and no status.
- R4: In mode 00, a CRC-16 (reflected polynomial 0x8408, initial value 0xFFFF) runs over the frame content including the two trailing FCS bytes. The frame is good only when the register ends at 0xF0B8. The two FCS bytes are never written, and the payload bytes are written in order.
- R5: In mode 01, every byte between the opening and closing flags is written, and no FCS check is made.
- R6: Seven consecutive 1s inside a frame give a status pulse with `statAbort`=1 and `statBad`=0. Bytes not yet written are dropped. No further status is given until a new flag arrives.
- R7: A frame with fewer than 2 content bytes, or with leftover bits that do not fill a byte, ends with `statBad`=1.
- R8: In mode 10, nothing is written until a bit arrives with `mfSync`=1. That bit starts a byte, and after it a byte is written every 8 bits. A later `mfSync` drops any partial byte and starts a new one.
- R9: In mode 11, each write carries 6 bits in `wrData[5:0]`, and the upper bits are zero. Alignment to `mfSync` is the same as in R8.
- R10: While `rxEn`=0 there are no writes, no status and no interrupt events, and all frame and alignment state is cleared.
- R11: `irqEvt` pulses with every status pulse in the HDLC modes and with every write in the transparent modes, and at no other time.
- R12: Cycles with `bitValid`=0 have no effect. Every output pulse appears in the cycle after the valid bit that causes it. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEn | input | 1 | Receive enable; 0 clears state and stops outputs |
| mode | input | 2 | Deformatting mode (see R1) |
| bitValid | input | 1 | Qualifies `bitIn` and `mfSync` in this cycle |
| bitIn | input | 1 | Received data link bit |
| mfSync | input | 1 | Marks the current bit as the first bit of a multiframe |
| wrEn | output | 1 | FIFO write strobe |
| wrData | output | 8 | FIFO write data |
| statValid | output | 1 | End-of-frame status pulse |
| statBad | output | 1 | Frame error (FCS, length or alignment), valid with `statValid` |
| statAbort | output | 1 | Frame aborted, valid with `statValid` |
| irqEvt | output | 1 | Receive interrupt-event pulse |

## Verification
HDLC frames of 0 to 8 payload bytes are built from payloads rich in 0xFF, 0xF8 and 0x7E. These show that zero deletion is right where a stuffed bit falls at a byte edge and that payload looking like a flag is not taken as a delimiter. Good frames are set against frames with one corrupted bit, too-short frames and frames with extra bits, which separates the FCS, length and alignment errors. An aborted frame checks how many held bytes were released before the abort, and the good frame after it shows that the block recovers. Transparent streams with unaligned leading bits, a mid-byte resync and both byte widths test alignment. A run with every third cycle invalid, and a run with the block disabled, show that qualified and disabled cycles leave no trace.

// File: rtl/hdlcrx_pkg.sv
package hdlcrx_pkg;

  typedef enum logic [1:0] {
    MODE_FCS   = 2'b00,
    MODE_NOFCS = 2'b01,
    MODE_PACK8 = 2'b10,
    MODE_PACK6 = 2'b11
  } rxMode_e;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic clr;      // receiver disabled: drop everything
    logic candV;    // destuffed bit enters the flag look-behind line
    logic candBit;  // current line bit
    logic flagHit;  // closing/opening flag completed on this bit
    logic abortHit; // seventh consecutive one
    logic uV;       // transparent bit to accumulate
    logic uAlign;   // transparent bit starts a byte (multiframe mark)
  } rxStrobe_t;

endpackage

// File: rtl/hdlcrx_ctrl.sv
module hdlcrx_ctrl
  import hdlcrx_pkg::*;
#(
  parameter int FLAG_RUN = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEn,
  input  logic [1:0] mode,
  input  logic       bitValid,
  input  logic       bitIn,
  input  logic       mfSync,
  output rxStrobe_t  stb
);

  localparam int CW = $clog2(FLAG_RUN + 2);
  localparam logic [CW-1:0] RUN_FLAG  = CW'(FLAG_RUN);
  localparam logic [CW-1:0] RUN_STUFF = CW'(FLAG_RUN - 1);
  localparam logic [CW-1:0] RUN_SAT   = CW'(FLAG_RUN + 1);

  logic [CW-1:0] onesCnt;
  logic          openQ;
  logic          alignedQ;
  logic          isHdlc;

  assign isHdlc = (mode == MODE_FCS) || (mode == MODE_NOFCS);

  always_comb begin
    stb         = '0;
    stb.clr     = !rxEn;
    stb.candBit = bitIn;
    if (rxEn && bitValid) begin
      if (isHdlc) begin
        if (onesCnt == RUN_FLAG) begin
          stb.abortHit = bitIn;
          stb.flagHit  = !bitIn;
        end else if (!(onesCnt == RUN_STUFF && !bitIn)) begin
          stb.candV = openQ;
        end
      end else begin
        stb.uAlign = mfSync;
        stb.uV     = mfSync || alignedQ;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesCnt  <= '0;
      openQ    <= 1'b0;
      alignedQ <= 1'b0;
    end else if (!rxEn) begin
      onesCnt  <= '0;
      openQ    <= 1'b0;
      alignedQ <= 1'b0;
    end else if (bitValid) begin
      if (isHdlc) begin
        if (!bitIn)                  onesCnt <= '0;
        else if (onesCnt != RUN_SAT) onesCnt <= onesCnt + 1'b1;
        if (stb.flagHit)       openQ <= 1'b1;
        else if (stb.abortHit) openQ <= 1'b0;
      end else if (mfSync) begin
        alignedQ <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hdlcrx_dp.sv
module hdlcrx_dp
  import hdlcrx_pkg::*;
#(
  parameter int              BYTE_W   = 8,
  parameter int              NARROW_W = 6,
  parameter int              FLAG_RUN = 6,
  parameter int              CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_GOOD = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  rxStrobe_t         stb,
  output logic              wrEn,
  output logic [BYTE_W-1:0] wrData,
  output logic              statValid,
  output logic              statBad,
  output logic              statAbort,
  output logic              irqEvt
);

  localparam int DLY = FLAG_RUN + 1;            // flag bits seen before recognition
  localparam int OCW = $clog2(DLY + 1);
  localparam int BCW = $clog2(BYTE_W + 1);
  localparam logic [OCW-1:0] OCC_FULL  = OCW'(DLY);
  localparam logic [BCW-1:0] LAST_WIDE = BCW'(BYTE_W - 1);
  localparam logic [BCW-1:0] LAST_NARR = BCW'(NARROW_W - 1);

  logic [DLY-1:0]    dly;
  logic [OCW-1:0]    occ;
  logic [BYTE_W-1:0] sh, newSh, hold0, hold1, uData;
  logic [BCW-1:0]    bitCnt, uLast;
  logic [1:0]        byteCnt;
  logic [CRC_W-1:0]  crc, crcNext;
  logic              exitV, inBit, byteDone, uDone, hasContent, frameBad;

  assign exitV      = stb.candV && (occ == OCC_FULL);
  assign inBit      = exitV ? dly[0] : stb.candBit;
  assign newSh      = {inBit, sh[BYTE_W-1:1]};
  assign byteDone   = exitV && (bitCnt == LAST_WIDE);
  assign hasContent = (byteCnt != 2'd0) || (bitCnt != '0);
  assign crcNext    = (crc >> 1) ^ ((crc[0] ^ dly[0]) ? CRC_POLY : '0);
  assign frameBad   = (byteCnt != 2'd2) || (bitCnt != '0) ||
                      ((mode == MODE_FCS) && (crc != CRC_GOOD));

  // transparent packing width
  generate
    if (NARROW_W < BYTE_W) begin : g_narrow
      assign uLast = mode[0] ? LAST_NARR : LAST_WIDE;
      assign uData = mode[0] ? (newSh >> (BYTE_W - NARROW_W)) : newSh;
    end else begin : g_wide
      assign uLast = LAST_WIDE;
      assign uData = newSh;
    end
  endgenerate
  assign uDone = stb.uV && !stb.uAlign && (bitCnt == uLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dly <= '0; occ <= '0; sh <= '0; bitCnt <= '0; byteCnt <= '0;
      crc <= '1; hold0 <= '0; hold1 <= '0;
      wrEn <= 1'b0; wrData <= '0; statValid <= 1'b0;
      statBad <= 1'b0; statAbort <= 1'b0; irqEvt <= 1'b0;
    end else begin
      wrEn      <= 1'b0;
      statValid <= 1'b0;
      statBad   <= 1'b0;
      statAbort <= 1'b0;
      irqEvt    <= 1'b0;
      if (stb.clr) begin
        occ <= '0; bitCnt <= '0; byteCnt <= '0; crc <= '1;
      end else if (stb.uV) begin
        sh <= newSh;
        if (stb.uAlign) begin
          bitCnt <= BCW'(1);
        end else if (uDone) begin
          bitCnt <= '0;
          wrEn   <= 1'b1;
          wrData <= uData;
          irqEvt <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else if (stb.flagHit || stb.abortHit) begin
        if (hasContent) begin
          statValid <= 1'b1;
          irqEvt    <= 1'b1;
          statAbort <= stb.abortHit;
          statBad   <= stb.flagHit && frameBad;
        end
        occ <= '0; bitCnt <= '0; byteCnt <= '0; crc <= '1;
      end else if (stb.candV) begin
        dly <= {stb.candBit, dly[DLY-1:1]};
        if (occ != OCC_FULL) occ <= occ + 1'b1;
        if (exitV) begin
          sh     <= newSh;
          crc    <= crcNext;
          bitCnt <= byteDone ? '0 : bitCnt + 1'b1;
          if (byteDone) begin
            if (byteCnt != 2'd2) byteCnt <= byteCnt + 1'b1;
            if (mode == MODE_NOFCS) begin
              wrEn   <= 1'b1;
              wrData <= newSh;
            end else if (byteCnt == 2'd2) begin
              wrEn   <= 1'b1;
              wrData <= hold0;
              hold0  <= hold1;
              hold1  <= newSh;
            end else if (byteCnt == 2'd1) begin
              hold1 <= newSh;
            end else begin
              hold0 <= newSh;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_rx_deformatter.sv
module hdlc_rx_deformatter
  import hdlcrx_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int NARROW_W = 6,
  parameter int FLAG_RUN = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEn,
  input  logic [1:0]        mode,
  input  logic              bitValid,
  input  logic              bitIn,
  input  logic              mfSync,
  output logic              wrEn,
  output logic [BYTE_W-1:0] wrData,
  output logic              statValid,
  output logic              statBad,
  output logic              statAbort,
  output logic              irqEvt
);

  rxStrobe_t stb;

  hdlcrx_ctrl #(.FLAG_RUN(FLAG_RUN)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .mode(mode),
    .bitValid(bitValid), .bitIn(bitIn), .mfSync(mfSync), .stb(stb)
  );

  hdlcrx_dp #(.BYTE_W(BYTE_W), .NARROW_W(NARROW_W), .FLAG_RUN(FLAG_RUN)) u_dp (
    .clk(clk), .rstN(rstN), .mode(mode), .stb(stb),
    .wrEn(wrEn), .wrData(wrData), .statValid(statValid),
    .statBad(statBad), .statAbort(statAbort), .irqEvt(irqEvt)
  );

endmodule

// File: rtl/hdlcrx_chk.sv
module hdlcrx_chk #(
  parameter int BYTE_W   = 8,
  parameter int NARROW_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEn,
  input logic [1:0]        mode,
  input logic              bitValid,
  input logic              wrEn,
  input logic [BYTE_W-1:0] wrData,
  input logic              statValid,
  input logic              statBad,
  input logic              statAbort,
  input logic              irqEvt
);

  a_r10_silent_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> (!wrEn && !statValid && !irqEvt));

  a_r12_idle_cycle_inert: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> (!wrEn && !statValid));

  a_r6_abort_not_bad: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> !(statBad && statAbort));

  a_r3_no_write_at_status: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> !wrEn);

  a_r9_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11) |=> (!wrEn || ((wrData >> NARROW_W) == '0)));

  a_r8_no_status_transparent: assert property (@(posedge clk) disable iff (!rstN)
    mode[1] |=> !statValid);

  a_r11_irq_tracks_status: assert property (@(posedge clk) disable iff (!rstN)
    (rxEn && !mode[1]) |=> (irqEvt == statValid));

  a_r11_irq_tracks_write: assert property (@(posedge clk) disable iff (!rstN)
    (rxEn && mode[1]) |=> (irqEvt == wrEn));

endmodule

bind hdlc_rx_deformatter hdlcrx_chk #(.BYTE_W(BYTE_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxEn(rxEn), .mode(mode), .bitValid(bitValid),
  .wrEn(wrEn), .wrData(wrData), .statValid(statValid), .statBad(statBad),
  .statAbort(statAbort), .irqEvt(irqEvt)
);

// File: tb/tb_hdlc_rx_deformatter.sv
`timescale 1ns/1ps
module tb_hdlc_rx_deformatter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEn = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       bitValid = 1'b0;
  logic       bitIn = 1'b0;
  logic       mfSync = 1'b0;
  logic       wrEn, statValid, statBad, statAbort, irqEvt;
  logic [7:0] wrData;

  int total = 0;
  int bad = 0;
  int irqCnt = 0;
  int onesRun = 0;
  int gapCnt = 0;
  bit gapOn = 0;
  logic [7:0] gotQ[$];
  logic [1:0] stQ[$];
  logic [7:0] pay [16];

  always #2 clk = ~clk;

  hdlc_rx_deformatter dut (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .mode(mode), .bitValid(bitValid),
    .bitIn(bitIn), .mfSync(mfSync), .wrEn(wrEn), .wrData(wrData),
    .statValid(statValid), .statBad(statBad), .statAbort(statAbort), .irqEvt(irqEvt)
  );

  always @(negedge clk) if (rstN) begin
    if (wrEn) gotQ.push_back(wrData);
    if (statValid) stQ.push_back({statBad, statAbort});
    if (irqEvt) irqCnt++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic putBit(logic b, logic sync = 1'b0);
    if (gapOn) begin
      gapCnt++;
      if (gapCnt % 3 == 0) begin
        @(negedge clk); bitValid = 1'b0; bitIn = 1'b1; mfSync = 1'b1;
      end
    end
    @(negedge clk); bitValid = 1'b1; bitIn = b; mfSync = sync;
  endtask

  task automatic quiet(int n);
    repeat (n) begin
      @(negedge clk); bitValid = 1'b0; bitIn = 1'b0; mfSync = 1'b0;
    end
  endtask

  task automatic rawByte(logic [7:0] v);
    for (int i = 0; i < 8; i++) putBit(v[i]);
    onesRun = 0;
  endtask

  task automatic stuffBit(logic b);
    putBit(b);
    if (b) begin
      onesRun++;
      if (onesRun == 5) begin putBit(1'b0); onesRun = 0; end
    end else onesRun = 0;
  endtask

  task automatic stuffByte(logic [7:0] v);
    for (int i = 0; i < 8; i++) stuffBit(v[i]);
  endtask

  function automatic logic [15:0] fcsOf(int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ pay[i][j];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  task automatic sendFrame(int n, bit fcs, bit corrupt, int extra);
    logic [15:0] f = fcsOf(n);
    if (corrupt) pay[0] = pay[0] ^ 8'h10;
    rawByte(8'h7E);
    for (int i = 0; i < n; i++) stuffByte(pay[i]);
    if (fcs) begin stuffByte(f[7:0]); stuffByte(f[15:8]); end
    for (int k = 0; k < extra; k++) stuffBit(k[0]);
    rawByte(8'h7E);
    rawByte(8'h7E);
    quiet(4);
  endtask

  task automatic startCase(logic [1:0] m);
    @(negedge clk); rxEn = 1'b0; bitValid = 1'b0;
    quiet(2);
    gotQ.delete(); stQ.delete(); irqCnt = 0; onesRun = 0;
    mode = m; rxEn = 1'b1;
    quiet(1);
  endtask

  task automatic expectFrame(string req, int nWr, int nStat, logic [1:0] lastSt);
    chk(gotQ.size() == nWr, {req, " write count"}, gotQ.size(), nWr);
    for (int i = 0; i < nWr && i < gotQ.size(); i++)
      chk(gotQ[i] == pay[i], {req, " byte"}, gotQ[i], pay[i]);
    chk(stQ.size() == nStat, {req, " status count"}, stQ.size(), nStat);
    if (nStat > 0 && stQ.size() > 0)
      chk(stQ[stQ.size()-1] == lastSt, {req, " status {bad,abort}"},
          stQ[stQ.size()-1], lastSt);
  endtask

  task automatic fillPay(int len);
    for (int i = 0; i < len; i++)
      case (i % 4)
        0: pay[i] = 8'hFF;
        1: pay[i] = 8'h7E;
        2: pay[i] = 8'(len * 29 + i * 71 + 8'h3E);
        default: pay[i] = 8'hF8;
      endcase
  endtask

  task automatic unfBits(logic [7:0] v, int w, bit sync);
    for (int i = 0; i < w; i++) putBit(v[i], (sync && i == 0));
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] expU [4];
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!wrEn && !statValid && !irqEvt, "R12 reset outputs", {wrEn, statValid, irqEvt}, 0);
    rstN = 1'b1;

    // R1 R2 R4 sweep of FCS frames, payloads needing zero deletion
    for (int len = 0; len <= 8; len++) begin
      startCase(2'b00);
      fillPay(len);
      sendFrame(len, 1, 0, 0);
      expectFrame("R2 R4 fcs frame", len, 1, 2'b00);
      chk(irqCnt == 1, "R11 irq per frame", irqCnt, 1);
    end

    // R12 invalid cycles interleaved
    startCase(2'b00);
    gapOn = 1; fillPay(5); sendFrame(5, 1, 0, 0); gapOn = 0;
    expectFrame("R12 gapped frame", 5, 1, 2'b00);

    // R4 corrupted frame
    startCase(2'b00);
    fillPay(4); sendFrame(4, 1, 1, 0);
    expectFrame("R4 bad fcs", 4, 1, 2'b10);

    // R3 idle flags, including shared-zero flags
    startCase(2'b00);
    rawByte(8'h7E); rawByte(8'h7E);
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 6; j++) putBit(1'b1);
      putBit(1'b0);
    end
    quiet(4);
    expectFrame("R3 idle flags", 0, 0, 2'b00);

    // R5 no-FCS mode writes all bytes
    for (int len = 2; len <= 6; len++) begin
      startCase(2'b01);
      fillPay(len);
      sendFrame(len, 0, 0, 0);
      expectFrame("R5 nofcs frame", len, 1, 2'b00);
    end

    // R7 short and non-octet frames
    startCase(2'b01);
    pay[0] = 8'h5C; sendFrame(1, 0, 0, 0);
    expectFrame("R7 short nofcs", 1, 1, 2'b10);
    startCase(2'b00);
    pay[0] = 8'h5C; sendFrame(1, 0, 0, 0);
    expectFrame("R7 short fcs", 0, 1, 2'b10);
    startCase(2'b01);
    pay[0] = 8'h12; pay[1] = 8'h34; pay[2] = 8'h56;
    sendFrame(3, 0, 0, 3);
    expectFrame("R7 non-octet", 3, 1, 2'b10);

    // R6 abort mid-frame, then recovery
    startCase(2'b00);
    pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33; pay[3] = 8'h44; pay[4] = 8'h00;
    rawByte(8'h7E);
    for (int i = 0; i < 5; i++) stuffByte(pay[i]);
    rawByte(8'hFF); rawByte(8'hFF); rawByte(8'hFF);
    quiet(4);
    expectFrame("R6 abort", 2, 1, 2'b01);
    gotQ.delete(); stQ.delete();
    pay[0] = 8'hA1; pay[1] = 8'hB2;
    sendFrame(2, 1, 0, 0);
    expectFrame("R6 recover", 2, 1, 2'b00);

    // R10 disabled receiver
    startCase(2'b00);
    @(negedge clk); rxEn = 1'b0;
    fillPay(3); sendFrame(3, 1, 0, 0);
    chk(gotQ.size() == 0 && stQ.size() == 0 && irqCnt == 0, "R10 disabled silent",
        gotQ.size() + stQ.size() + irqCnt, 0);
    @(negedge clk); rxEn = 1'b1;
    sendFrame(3, 1, 0, 0);
    expectFrame("R10 re-enabled", 3, 1, 2'b00);

    // R8 pack8 alignment and resync
    startCase(2'b10);
    putBit(1); putBit(0); putBit(1); putBit(1); putBit(0);
    unfBits(8'hA5, 8, 1); unfBits(8'h3C, 8, 0); unfBits(8'h81, 8, 0);
    putBit(1); putBit(1); putBit(1);
    unfBits(8'h5A, 8, 1);
    quiet(3);
    expU[0] = 8'hA5; expU[1] = 8'h3C; expU[2] = 8'h81; expU[3] = 8'h5A;
    chk(gotQ.size() == 4, "R8 pack8 count", gotQ.size(), 4);
    for (int i = 0; i < 4 && i < gotQ.size(); i++)
      chk(gotQ[i] == expU[i], "R8 pack8 byte", gotQ[i], expU[i]);
    chk(irqCnt == 4 && stQ.size() == 0, "R11 pack8 irq", irqCnt, 4);

    // R9 pack6
    startCase(2'b11);
    putBit(0); putBit(1);
    unfBits(8'h2B, 6, 1); unfBits(8'h15, 6, 0); unfBits(8'h3F, 6, 0);
    quiet(3);
    expU[0] = 8'h2B; expU[1] = 8'h15; expU[2] = 8'h3F;
    chk(gotQ.size() == 3, "R9 pack6 count", gotQ.size(), 3);
    for (int i = 0; i < 3 && i < gotQ.size(); i++)
      chk(gotQ[i] == expU[i], "R9 pack6 byte", gotQ[i], expU[i]);
    chk(irqCnt == 3, "R11 pack6 irq", irqCnt, 3);

    summary();
  end

endmodule